// File: doc/BRIEF.md
# Four-Tap Quasi-Cyclic Convolution Systolic Chain

This block evaluates a 4-point matrix-vector product whose matrix has constant diagonals that differ only in sign: each row is the previous row rotated by one place, with the entries that wrap from the end of a row to its start negated. A product of this kind yields one group of odd-frequency outputs of a 16-point integer DCT, once butterfly stages have formed the difference samples that feed it. Those butterflies, and the stage that later combines the outputs, live outside this block.

Four identical processing elements form a chain. Each element holds a fixed small coefficient and forms its product only from shifted copies of the operand, added or subtracted. Every element also adds or subtracts that product into the partial sum arriving from its left neighbour. A one-bit tag per element, supplied with every shift command, picks the sign. The partial sums march one element to the right per shift, so the chain's last element always holds the signed weighted sum of the last four samples. To form the quasi-cyclic rows, the caller streams u0..u3 followed by u0..u2 again, with every tag set on those last three re-fed samples. Output-take commands then move each finished row from the chain's end into a four-lane result register.

Top module: `qconv4_array`

## Requirements
- R1: While rst_n is low at a clock edge, every partial sum and every result lane becomes zero by that edge.
- R2: Element j (j = 0 is the element that starts the chain) weights its sample by the fixed magnitude c[j], with c = (127, 81, 13, 100) by default. The magnitude is built from shifts and adds only.
- R3: On a shift, sign_tag bit j = 1 makes element j subtract its product from the incoming partial sum, and bit j = 0 makes it add. Each bit acts on its own element only.
- R4: The partial sums change only on edges where shift_en is high. Samples and tags presented on other cycles have no effect on any later result.
- R5: Let w(t) be the sample of the t-th shift and s(t,j) = -1 if sign_tag[j] was 1 at that shift, else +1. After the shift that takes w(t), the chain end holds the sum over j = 0..3 of s(t-3+j, j)·c[j]·w(t-3+j).
- R6: Each edge with out_take high moves lanes 3..1 down into lanes 2..0 and loads lane 3 with the chain-end value. After four takes, lane k holds the k-th value taken. Lane k occupies y_lanes bits [18k+17 : 18k].
- R7: Feed u0,u1,u2,u3,u0,u1,u2 on seven shifts, with sign_tag = 4'b0000 on the first four and 4'b1111 on the last three. Take on the four cycles after the fourth shift. Lane r then equals the sum over j of σ·c[j]·u[(r+j) mod 4], with σ = -1 when r+j ≥ 4 and +1 otherwise.
- R8: When out_take and shift_en are both high in one cycle, the take captures the chain-end value from before that cycle's shift.
- R9: Results are exact, two's-complement and 18 bits wide for all 9-bit signed samples, including all-(-256), all-(+255) and alternating extremes.
- R10: The result lanes keep their values on every edge where out_take is low, shifts included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Takes sample_in and advances the partial sums by one element |
| sample_in | input | 9 | Signed sample broadcast to all elements on a shift |
| sign_tag | input | 4 | Per-element subtract select, bit j for element j |
| out_take | input | 1 | Moves the chain-end value into the result lanes |
| y_lanes | output | 72 | Four signed 18-bit result lanes, lane k at bits [18k+17:18k] |

## Verification
Several properties are checked on every cycle. The chain freezes without a shift, and the lanes freeze without a take. A take loads the top lane from the chain end and moves the other lanes down. Reset clears everything. The chain end stays within the bound that four maximal products allow. The values themselves can only be shown by the bench's scenarios. These compare the lanes against a matrix-vector product computed directly from the inputs. The scenarios cover random and extreme vectors, a unit impulse that exposes each coefficient and its wrap sign, arbitrary per-element tags, idle cycles with noise inside a frame, and shifts without takes.

// File: rtl/qconv4_pkg.sv
// Shared constants and elaboration-time helpers for the quasi-cyclic chain.
// Assumes every tap coefficient is a positive integer below 2**COEF_W.
package qconv4_pkg;

    localparam int COEF_W = 8;

    // Canonical signed-digit recoding: returns the positive or negative digit mask.
    function automatic logic [COEF_W:0] csd_mask(input int unsigned c, input bit want_neg);
        logic [COEF_W:0] pos_m;
        logic [COEF_W:0] neg_m;
        int unsigned     n;
        pos_m = '0;
        neg_m = '0;
        n     = c;
        for (int i = 0; i <= COEF_W; i++) begin
            if (n[0]) begin
                if (n[1]) begin
                    neg_m[i] = 1'b1;
                    n        = n + 1;
                end else begin
                    pos_m[i] = 1'b1;
                    n        = n - 1;
                end
            end
            n = n >> 1;
        end
        return want_neg ? neg_m : pos_m;
    endfunction

endpackage

// File: rtl/qconv4_cmul.sv
// Multiplier by a fixed positive constant, built from shifted operand copies
// that are added or subtracted according to the constant's signed-digit form.
// Assumes PW is wide enough for XW + COEF_W + 1 bits.
module qconv4_cmul
    import qconv4_pkg::*;
#(
    parameter int          XW   = 9,
    parameter int          PW   = 18,
    parameter int unsigned COEF = 127
) (
    input  logic signed [XW-1:0] x,
    output logic signed [PW-1:0] p
);

    localparam logic [COEF_W:0] POS_D = csd_mask(COEF, 1'b0);
    localparam logic [COEF_W:0] NEG_D = csd_mask(COEF, 1'b1);
    localparam int              NDIG  = COEF_W + 1;

    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] term [NDIG];

    assign xe = {{(PW-XW){x[XW-1]}}, x};

    // One term per digit position: +x<<k, -x<<k or zero.
    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        if (POS_D[k]) begin : g_pos
            assign term[k] = xe <<< k;
        end else if (NEG_D[k]) begin : g_neg
            assign term[k] = -(xe <<< k);
        end else begin : g_zero
            assign term[k] = '0;
        end
    end

    // Adds the digit terms into the product.
    always_comb begin
        p = '0;
        for (int k = 0; k < NDIG; k++) begin
            p = p + term[k];
        end
    end

endmodule

// File: rtl/qconv4_pe.sv
// One processing element: a constant product of the broadcast sample,
// added to or subtracted from the left neighbour's partial sum on a shift.
// Assumes AW holds the largest partial sum the chain can form.
module qconv4_pe #(
    parameter int          XW   = 9,
    parameter int          AW   = 18,
    parameter int unsigned COEF = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [XW-1:0] x,
    input  logic                 sub,
    input  logic signed [AW-1:0] ps_in,
    output logic signed [AW-1:0] ps_out
);

    logic signed [AW-1:0] prod;

    qconv4_cmul #(.XW(XW), .PW(AW), .COEF(COEF)) cmul_i (
        .x (x),
        .p (prod)
    );

    // Registers the signed accumulation when the chain advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_out <= '0;
        end else if (shift_en) begin
            ps_out <= sub ? (ps_in - prod) : (ps_in + prod);
        end
    end

endmodule

// File: rtl/qconv4_collect.sv
// Result lanes: each take moves the lanes down by one and loads the top
// lane from the chain end, so lane k ends up holding the k-th value taken.
module qconv4_collect #(
    parameter int AW   = 18,
    parameter int NTAP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic signed [AW-1:0]   tail,
    output logic [NTAP*AW-1:0]     lanes_flat
);

    logic signed [AW-1:0] lane [NTAP];

    // Moves the lanes down and loads the top one on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP; i++) lane[i] <= '0;
        end else if (take) begin
            for (int i = 0; i < NTAP-1; i++) lane[i] <= lane[i+1];
            lane[NTAP-1] <= tail;
        end
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_flat
        assign lanes_flat[k*AW +: AW] = lane[k];
    end

endmodule

// File: rtl/qconv4_array.sv
// Top of the quasi-cyclic convolution chain. The sample is broadcast to all
// elements, and the partial sums move one element to the right per shift.
// The sign tags make the product quasi-cyclic. Assumes the caller sequences
// shifts, tags and takes as the brief describes.
module qconv4_array #(
    parameter int          XW   = 9,
    parameter int          AW   = 18,
    parameter int          NTAP = 4,
    parameter int unsigned COEFS [NTAP] = '{127, 81, 13, 100}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [XW-1:0] sample_in,
    input  logic [NTAP-1:0]      sign_tag,
    input  logic                 out_take,
    output logic [NTAP*AW-1:0]   y_lanes
);

    logic signed [AW-1:0] ps [NTAP];
    logic signed [AW-1:0] chain_tail;

    // Chain of identical elements; the first starts from a zero partial sum.
    for (genvar j = 0; j < NTAP; j++) begin : g_pe
        logic signed [AW-1:0] left_sum;
        if (j == 0) begin : g_head
            assign left_sum = '0;
        end else begin : g_link
            assign left_sum = ps[j-1];
        end
        qconv4_pe #(.XW(XW), .AW(AW), .COEF(COEFS[j])) pe_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .x        (sample_in),
            .sub      (sign_tag[j]),
            .ps_in    (left_sum),
            .ps_out   (ps[j])
        );
    end

    assign chain_tail = ps[NTAP-1];

    qconv4_collect #(.AW(AW), .NTAP(NTAP)) collect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (out_take),
        .tail       (chain_tail),
        .lanes_flat (y_lanes)
    );

endmodule

// File: rtl/qconv4_chk.sv
// Cycle-level properties of the chain, bound to the top module.
module qconv4_chk #(
    parameter int          XW   = 9,
    parameter int          AW   = 18,
    parameter int          NTAP = 4,
    parameter int unsigned COEFS [NTAP] = '{127, 81, 13, 100}
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shift_en,
    input logic                 out_take,
    input logic [NTAP*AW-1:0]   y_lanes,
    input logic signed [AW-1:0] tail
);

    int bound;

    // Largest magnitude four extreme samples can produce.
    always_comb begin
        bound = 0;
        for (int j = 0; j < NTAP; j++) bound = bound + int'(COEFS[j]) * (2 ** (XW-1));
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (y_lanes == '0 && tail == '0)); // R1

    AST_CHAIN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(tail)); // R4

    AST_TAKE_LOADS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_take |=> $signed(y_lanes[NTAP*AW-1 -: AW]) == $past(tail)); // R8

    AST_TAKE_MOVES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_take |=> y_lanes[(NTAP-1)*AW-1:0] == $past(y_lanes[NTAP*AW-1:AW])); // R6

    AST_LANES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_take |=> $stable(y_lanes)); // R10

    AST_TAIL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tail) <= bound) && (int'(tail) >= -bound)); // R9

endmodule

bind qconv4_array qconv4_chk #(.XW(XW), .AW(AW), .NTAP(NTAP), .COEFS(COEFS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .out_take (out_take),
    .y_lanes  (y_lanes),
    .tail     (chain_tail)
);

// File: tb/qconv4_array_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module qconv4_array_tb_top;

    localparam int XW = 9;
    localparam int AW = 18;
    localparam int NT = 4;
    localparam int NSH = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              shift_en = 1'b0;
    logic signed [8:0] sample_in = '0;
    logic [3:0]        sign_tag = '0;
    logic              out_take = 1'b0;
    logic [71:0]       y_lanes;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    int          coef [NT] = '{127, 81, 13, 100};
    logic signed [8:0] stim_w [NSH];
    logic [3:0]        stim_tg [NSH];
    int          uvec [NT];

    always #10 clk = ~clk;

    qconv4_array dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sample_in (sample_in),
        .sign_tag  (sign_tag),
        .out_take  (out_take),
        .y_lanes   (y_lanes)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    function automatic int lane_val(int k);
        logic signed [17:0] v;
        v = y_lanes[k*AW +: AW];
        return int'(v);
    endfunction

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Stream model of R5: row r collects shifts r..r+3, element j at shift r+j.
    function automatic int stream_row(int r);
        int acc = 0;
        for (int j = 0; j < NT; j++) begin
            if (stim_tg[r+j][j]) acc -= coef[j] * int'(stim_w[r+j]);
            else                 acc += coef[j] * int'(stim_w[r+j]);
        end
        return acc;
    endfunction

    // Direct quasi-cyclic product of R7.
    function automatic int qc_row(int r);
        int acc = 0;
        for (int j = 0; j < NT; j++) begin
            if (r + j >= NT) acc -= coef[j] * uvec[(r+j) % NT];
            else             acc += coef[j] * uvec[r+j];
        end
        return acc;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; shift_en = 1'b0; out_take = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Seven shifts; takes share the cycle with shifts 4..6, then one lone take (R8).
    task automatic run_frame(bit gaps);
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            shift_en  = (t < NSH);
            sample_in = (t < NSH) ? stim_w[t] : 9'sd0;
            sign_tag  = (t < NSH) ? stim_tg[t] : 4'b0000;
            out_take  = (t >= 4);
            if (gaps && t < 7) begin
                @(negedge clk);
                shift_en  = 1'b0;
                out_take  = 1'b0;
                sample_in = 9'($urandom_range(511));
                sign_tag  = 4'($urandom_range(15));
            end
        end
        @(negedge clk);
        shift_en = 1'b0;
        out_take = 1'b0;
    endtask

    task automatic load_qc();
        for (int t = 0; t < NSH; t++) begin
            stim_w[t]  = 9'(uvec[t % NT]);
            stim_tg[t] = (t >= NT) ? 4'b1111 : 4'b0000;
        end
    endtask

    task automatic test_reset();
        do_reset();
        for (int k = 0; k < NT; k++) check("R1 lane after reset", lane_val(k), 0);
    endtask

    task automatic test_impulse();
        uvec = '{1, 0, 0, 0};
        load_qc();
        run_frame(1'b0);
        check("R2 lane0 coef 127", lane_val(0), 127);
        check("R2 lane1 wrapped coef 100", lane_val(1), -100);
        check("R2 lane2 wrapped coef 13", lane_val(2), -13);
        check("R2 lane3 wrapped coef 81", lane_val(3), -81);
    endtask

    task automatic test_quasi_random();
        for (int f = 0; f < 6; f++) begin
            for (int i = 0; i < NT; i++) uvec[i] = $urandom_range(511) - 256;
            load_qc();
            run_frame(1'b0);
            for (int k = 0; k < NT; k++) check("R7 R6 R8 quasi-cyclic lane", lane_val(k), qc_row(k));
        end
    endtask

    task automatic test_extremes();
        int pat [3][NT] = '{'{-256, -256, -256, -256}, '{255, 255, 255, 255}, '{255, -256, 255, -256}};
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < NT; i++) uvec[i] = pat[p][i];
            load_qc();
            run_frame(1'b0);
            for (int k = 0; k < NT; k++) check("R9 extreme lane", lane_val(k), qc_row(k));
        end
    endtask

    task automatic test_free_tags(bit gaps);
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < NSH; t++) begin
                stim_w[t]  = 9'($urandom_range(511));
                stim_tg[t] = 4'($urandom_range(15));
            end
            run_frame(gaps);
            for (int k = 0; k < NT; k++) begin
                if (gaps) check("R4 idle cycles ignored", lane_val(k), stream_row(k));
                else      check("R3 R5 per-element tags", lane_val(k), stream_row(k));
            end
        end
    endtask

    task automatic test_hold();
        int keep [NT];
        for (int k = 0; k < NT; k++) keep[k] = lane_val(k);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            shift_en  = 1'b1;
            out_take  = 1'b0;
            sample_in = 9'($urandom_range(511));
            sign_tag  = 4'($urandom_range(15));
        end
        @(negedge clk);
        shift_en = 1'b0;
        for (int k = 0; k < NT; k++) check("R10 lanes hold without take", lane_val(k), keep[k]);
    endtask

    initial begin
        test_reset();
        test_impulse();
        test_quasi_random();
        test_extremes();
        test_free_tags(1'b0);
        test_free_tags(1'b1);
        test_hold();
        test_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule